// File: doc/BRIEF.md
# ADC conversion and calibration sequencer

This block is the digital control core of a successive-approximation converter. It accepts a start request from a convert-start pin or from a software start bit. It also accepts calibration requests from a start-calibration bit or from a dedicated CAL pin. For each operation it holds BUSY high for a fixed number of master clock cycles. It emits one-cycle start and done strobes toward an abstract converter datapath, and it reports which kind of calibration is running.

The pins arrive asynchronously. The convert-start, CAL and sleep pins each pass through a two-flop synchronizer in the master clock domain. The sequencer then detects edges on the synchronized levels. A low CAL level overrides everything: it abandons any running operation and holds the sequencer idle. The rising edge of CAL launches a full self-calibration.

A sleep request powers the part down only while the sequencer is idle. The two power-management bits choose between the full and the partial low-power state. The software start bit and the start-calibration bit are set when their operation is accepted, and hardware clears them when that operation ends.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, sw_conv_bit, stcal_bit, all four strobes, cal_kind and both power-down outputs are low.
- R2: A rising edge on convst_pin, after synchronization, begins a conversion. busy is high for exactly CONV_CYCLES cycles. conv_start is high in the first busy cycle. conv_done is a one-cycle pulse in the first cycle after busy falls. cal_kind is 00 during a conversion.
- R3: A one-cycle pulse on sw_conv_set while idle begins a conversion of the same length as R2. sw_conv_bit is high throughout that conversion and is clear once it ends.
- R4: A one-cycle pulse on stcal_set while idle begins a calibration and sets stcal_bit until the calibration ends. The calibration kind is decoded as follows, and cal_kind shows the code while busy:
  - cal_mode=0 gives a self calibration, code 01, lasting CAL_SELF_CYCLES.
  - cal_mode=1 with cal_sel=01 gives an offset calibration, code 11, lasting CAL_OFFS_CYCLES.
  - cal_mode=1 with any other cal_sel gives a full-scale calibration, code 10, lasting CAL_FS_CYCLES.
  
  cal_start is high in the first busy cycle. cal_done pulses in the first cycle after busy falls.
- R5: A rising edge on cal_pin starts a self calibration (code 01) lasting CAL_SELF_CYCLES, with cal_start and cal_done as in R4.
- R6: While cal_pin is low (synchronized), the following hold:
  - busy is low.
  - Any running operation is abandoned with no done strobe.
  - sw_conv_bit and stcal_bit are clear.
  - Every start request is ignored.
- R7: Start requests that arrive while busy is high are ignored. The running operation keeps its length, neither control bit is set, and no further operation follows.
- R8: A low sleep_n_pin asserts a power-down output only while the sequencer is idle. During an operation both outputs stay low, and one of them asserts once the operation ends.
- R9: During a power-down, pmgt=11 selects pwr_partial_down. Any other pmgt value selects pwr_full_down. At most one of the two is high.
- R10: When stcal_set and sw_conv_set pulse in the same idle cycle, the calibration runs, the conversion is dropped, and sw_conv_bit stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| convst_pin | input | 1 | Asynchronous convert-start pin, rising edge starts |
| cal_pin | input | 1 | Asynchronous calibration pin, low aborts, rising edge calibrates |
| sleep_n_pin | input | 1 | Asynchronous sleep request, active low |
| sw_conv_set | input | 1 | One-cycle write of 1 to the software start bit |
| stcal_set | input | 1 | One-cycle write of 1 to the start-calibration bit |
| cal_mode | input | 1 | 0 self, 1 system calibration |
| cal_sel | input | 2 | Calibration select field |
| pmgt | input | 2 | Power-management field |
| busy | output | 1 | Operation in progress |
| sw_conv_bit | output | 1 | Software start bit, self-clearing |
| stcal_bit | output | 1 | Start-calibration bit, self-clearing |
| conv_start | output | 1 | Conversion start strobe to datapath |
| conv_done | output | 1 | Conversion done strobe |
| cal_start | output | 1 | Calibration start strobe |
| cal_done | output | 1 | Calibration done strobe |
| cal_kind | output | 2 | Running calibration kind: 00 none, 01 self, 10 full-scale, 11 offset |
| pwr_full_down | output | 1 | Full power-down state |
| pwr_partial_down | output | 1 | Partial power-down state |

## Verification
The bench keeps CONV_CYCLES at its real value of 18. It shrinks the calibration budgets to 200, 150 and 40 cycles, so that every calibration kind, and a CAL abort in the middle of a calibration, completes in a short run. Because the three budgets are distinct, a wrong mode/select decode shows up as a wrong busy length. The measured length is cycle-exact, so an off-by-one in the counter load or at its terminal count is caught.

// File: rtl/adc_seq_pkg.sv
// Package: shared types for the ADC sequencer.
// Assumes: cal kind codes are visible at the block's ports.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_CAL  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'b00,
        KIND_SELF = 2'b01,
        KIND_FS   = 2'b10,
        KIND_OFFS = 2'b11
    } cal_kind_e;

    // Map mode and select fields to a calibration kind.
    function automatic cal_kind_e decode_cal(logic mode, logic [1:0] sel);
        if (!mode)
            return KIND_SELF;
        else if (sel == 2'b01)
            return KIND_OFFS;
        else
            return KIND_FS;
    endfunction

endpackage

// File: rtl/adc_seq_sync.sv
// Module: two-flop synchronizer bank for asynchronous pins.
// Assumes: each bit is an independent level; RST_VAL gives each bit's
// inactive level so that reset produces no false edge downstream.
module adc_seq_sync #(
    parameter int             WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] lvl_out
);

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one pin into the master clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[gi];
                stab_q <= RST_VAL[gi];
            end else begin
                meta_q <= pin_in[gi];
                stab_q <= meta_q;
            end
        end

        assign lvl_out[gi] = stab_q;
    end

endmodule

// File: rtl/adc_seq_core.sv
// Module: sequencer state machine and cycle budget counter.
// Assumes: conv_lvl and cal_lvl are already synchronized; the software
// set inputs are single-cycle pulses. Priority in idle: CAL edge, then
// start-calibration, then conversion.
module adc_seq_core
    import adc_seq_pkg::*;
#(
    parameter int CONV_CYCLES     = 18,
    parameter int CAL_SELF_CYCLES = 125013,
    parameter int CAL_FS_CYCLES   = 111114,
    parameter int CAL_OFFS_CYCLES = 13899
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conv_lvl,
    input  logic       cal_lvl,
    input  logic       sw_conv_set,
    input  logic       stcal_set,
    input  logic       cal_mode,
    input  logic [1:0] cal_sel,
    output logic       busy,
    output logic       sw_conv_bit,
    output logic       stcal_bit,
    output logic       conv_start,
    output logic       conv_done,
    output logic       cal_start,
    output logic       cal_done,
    output logic [1:0] cal_kind,
    output logic       idle_next
);

    localparam int MAX_A = (CAL_SELF_CYCLES > CAL_FS_CYCLES) ? CAL_SELF_CYCLES : CAL_FS_CYCLES;
    localparam int MAX_B = (CAL_OFFS_CYCLES > CONV_CYCLES) ? CAL_OFFS_CYCLES : CONV_CYCLES;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_C + 1);

    seq_state_e       state_q, state_d;
    cal_kind_e        kind_q, kind_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             swb_d, stb_d;
    logic             cs_d, cd_d, ks_d, kd_d;
    logic             conv_prev_q, cal_prev_q;
    logic             conv_rise, cal_rise, cal_low;
    cal_kind_e        req_kind;

    // Counter load value for a calibration kind.
    function automatic logic [CNT_W-1:0] cal_budget(cal_kind_e k);
        case (k)
            KIND_OFFS: return CNT_W'(CAL_OFFS_CYCLES - 1);
            KIND_FS:   return CNT_W'(CAL_FS_CYCLES - 1);
            default:   return CNT_W'(CAL_SELF_CYCLES - 1);
        endcase
    endfunction

    // Remember previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_prev_q <= 1'b0;
            cal_prev_q  <= 1'b1;
        end else begin
            conv_prev_q <= conv_lvl;
            cal_prev_q  <= cal_lvl;
        end
    end

    assign conv_rise = conv_lvl & ~conv_prev_q;
    assign cal_rise  = cal_lvl & ~cal_prev_q;
    assign cal_low   = ~cal_lvl;
    assign req_kind  = decode_cal(cal_mode, cal_sel);

    // Next-state, counter and strobe decisions.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        kind_d  = kind_q;
        swb_d   = sw_conv_bit;
        stb_d   = stcal_bit;
        cs_d    = 1'b0;
        cd_d    = 1'b0;
        ks_d    = 1'b0;
        kd_d    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cal_low) begin
                    swb_d = 1'b0;
                    stb_d = 1'b0;
                end else if (cal_rise) begin
                    state_d = ST_CAL;
                    kind_d  = KIND_SELF;
                    cnt_d   = cal_budget(KIND_SELF);
                    ks_d    = 1'b1;
                end else if (stcal_set) begin
                    state_d = ST_CAL;
                    kind_d  = req_kind;
                    cnt_d   = cal_budget(req_kind);
                    ks_d    = 1'b1;
                    stb_d   = 1'b1;
                end else if (conv_rise || sw_conv_set) begin
                    state_d = ST_CONV;
                    cnt_d   = CNT_W'(CONV_CYCLES - 1);
                    cs_d    = 1'b1;
                    swb_d   = sw_conv_set;
                end
            end
            default: begin
                if (cal_low) begin
                    state_d = ST_IDLE;
                    kind_d  = KIND_NONE;
                    swb_d   = 1'b0;
                    stb_d   = 1'b0;
                end else if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                    kind_d  = KIND_NONE;
                    swb_d   = 1'b0;
                    stb_d   = 1'b0;
                    if (state_q == ST_CONV)
                        cd_d = 1'b1;
                    else
                        kd_d = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    // Sequencer registers and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            kind_q      <= KIND_NONE;
            cnt_q       <= '0;
            sw_conv_bit <= 1'b0;
            stcal_bit   <= 1'b0;
            conv_start  <= 1'b0;
            conv_done   <= 1'b0;
            cal_start   <= 1'b0;
            cal_done    <= 1'b0;
        end else begin
            state_q     <= state_d;
            kind_q      <= kind_d;
            cnt_q       <= cnt_d;
            sw_conv_bit <= swb_d;
            stcal_bit   <= stb_d;
            conv_start  <= cs_d;
            conv_done   <= cd_d;
            cal_start   <= ks_d;
            cal_done    <= kd_d;
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign cal_kind  = kind_q;
    assign idle_next = (state_d == ST_IDLE);

    // R2
    conv_done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> $past(busy));

    // R4
    cal_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> !busy);

    // R2
    start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (conv_start || cal_start));

    // R3
    swbit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_conv_bit |-> (busy && cal_kind == 2'b00));

    // R7
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sw_conv_bit) |=> !sw_conv_bit);

    // R6
    cal_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_lvl && !cal_prev_q) |=> (!busy && !conv_done && !cal_done));

endmodule

// File: rtl/adc_seq_power.sv
// Module: sleep request gating and power-state selection.
// Assumes: sleep_req is synchronized; idle_next is the sequencer's next
// state being idle, so the outputs and busy change on the same edge.
module adc_seq_power (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       idle_next,
    input  logic       busy,
    input  logic [1:0] pmgt,
    output logic       pwr_full_down,
    output logic       pwr_partial_down
);

    logic pd_ok;
    logic partial_sel;

    assign pd_ok       = sleep_req && idle_next;
    assign partial_sel = (pmgt == 2'b11);

    // Register the selected low-power state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_full_down    <= 1'b0;
            pwr_partial_down <= 1'b0;
        end else begin
            pwr_full_down    <= pd_ok && !partial_sel;
            pwr_partial_down <= pd_ok && partial_sel;
        end
    end

    // R9
    pwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pwr_full_down, pwr_partial_down}));

    // R8
    pwr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_full_down || pwr_partial_down) |-> !busy);

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: top of the ADC conversion and calibration sequencer.
// Assumes: pins are asynchronous to clk; software set inputs are
// one-cycle pulses in the clk domain.
module adc_seq_ctrl #(
    parameter int CONV_CYCLES     = 18,
    parameter int CAL_SELF_CYCLES = 125013,
    parameter int CAL_FS_CYCLES   = 111114,
    parameter int CAL_OFFS_CYCLES = 13899
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       convst_pin,
    input  logic       cal_pin,
    input  logic       sleep_n_pin,
    input  logic       sw_conv_set,
    input  logic       stcal_set,
    input  logic       cal_mode,
    input  logic [1:0] cal_sel,
    input  logic [1:0] pmgt,
    output logic       busy,
    output logic       sw_conv_bit,
    output logic       stcal_bit,
    output logic       conv_start,
    output logic       conv_done,
    output logic       cal_start,
    output logic       cal_done,
    output logic [1:0] cal_kind,
    output logic       pwr_full_down,
    output logic       pwr_partial_down
);

    localparam int NPINS = 3;

    logic [NPINS-1:0] pins_lvl;
    logic             idle_next;

    adc_seq_sync #(
        .WIDTH   (NPINS),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  ({sleep_n_pin, cal_pin, convst_pin}),
        .lvl_out (pins_lvl)
    );

    adc_seq_core #(
        .CONV_CYCLES     (CONV_CYCLES),
        .CAL_SELF_CYCLES (CAL_SELF_CYCLES),
        .CAL_FS_CYCLES   (CAL_FS_CYCLES),
        .CAL_OFFS_CYCLES (CAL_OFFS_CYCLES)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_lvl    (pins_lvl[0]),
        .cal_lvl     (pins_lvl[1]),
        .sw_conv_set (sw_conv_set),
        .stcal_set   (stcal_set),
        .cal_mode    (cal_mode),
        .cal_sel     (cal_sel),
        .busy        (busy),
        .sw_conv_bit (sw_conv_bit),
        .stcal_bit   (stcal_bit),
        .conv_start  (conv_start),
        .conv_done   (conv_done),
        .cal_start   (cal_start),
        .cal_done    (cal_done),
        .cal_kind    (cal_kind),
        .idle_next   (idle_next)
    );

    adc_seq_power u_power (
        .clk              (clk),
        .rst_n            (rst_n),
        .sleep_req        (~pins_lvl[2]),
        .idle_next        (idle_next),
        .busy             (busy),
        .pmgt             (pmgt),
        .pwr_full_down    (pwr_full_down),
        .pwr_partial_down (pwr_partial_down)
    );

endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;

    localparam int CONV = 18;
    localparam int CSELF = 200;
    localparam int CFS = 150;
    localparam int COFFS = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic convst_pin = 1'b0, cal_pin = 1'b1, sleep_n_pin = 1'b1;
    logic sw_conv_set = 1'b0, stcal_set = 1'b0, cal_mode = 1'b0;
    logic [1:0] cal_sel = 2'b00, pmgt = 2'b00;
    logic busy, sw_conv_bit, stcal_bit, conv_start, conv_done, cal_start, cal_done;
    logic [1:0] cal_kind;
    logic pwr_full_down, pwr_partial_down;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl #(
        .CONV_CYCLES(CONV), .CAL_SELF_CYCLES(CSELF),
        .CAL_FS_CYCLES(CFS), .CAL_OFFS_CYCLES(COFFS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .convst_pin(convst_pin), .cal_pin(cal_pin),
        .sleep_n_pin(sleep_n_pin), .sw_conv_set(sw_conv_set), .stcal_set(stcal_set),
        .cal_mode(cal_mode), .cal_sel(cal_sel), .pmgt(pmgt), .busy(busy),
        .sw_conv_bit(sw_conv_bit), .stcal_bit(stcal_bit), .conv_start(conv_start),
        .conv_done(conv_done), .cal_start(cal_start), .cal_done(cal_done),
        .cal_kind(cal_kind), .pwr_full_down(pwr_full_down),
        .pwr_partial_down(pwr_partial_down)
    );

    // op: 0 convst pin, 1 software start, 2 start-calibration, 3 CAL pin
    typedef struct packed {
        logic [1:0]  op;
        logic        mode;
        logic [1:0]  sel;
        logic [15:0] len;
        logic [1:0]  kind;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'd0, 1'b0, 2'b00, 16'(CONV),  2'b00},
        '{2'd1, 1'b0, 2'b00, 16'(CONV),  2'b00},
        '{2'd2, 1'b0, 2'b00, 16'(CSELF), 2'b01},
        '{2'd2, 1'b0, 2'b10, 16'(CSELF), 2'b01},
        '{2'd2, 1'b1, 2'b00, 16'(CFS),   2'b10},
        '{2'd2, 1'b1, 2'b01, 16'(COFFS), 2'b11},
        '{2'd2, 1'b1, 2'b11, 16'(CFS),   2'b10},
        '{2'd3, 1'b0, 2'b00, 16'(CSELF), 2'b01}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Measure one busy window; start sampling at the current negedge.
    task automatic measure(output int len, output logic [1:0] kind,
                           output logic st_c, output logic st_k,
                           output logic swb, output logic stb,
                           output logic dn_c, output logic dn_k);
        len = 0; kind = 2'b00; st_c = 0; st_k = 0; swb = 0; stb = 0;
        dn_c = 0; dn_k = 0;
        for (int i = 0; i < 60; i++) begin
            if (busy) break;
            @(negedge clk);
        end
        if (!busy) return;
        len = 1; kind = cal_kind; st_c = conv_start; st_k = cal_start;
        swb = sw_conv_bit; stb = stcal_bit;
        forever begin
            @(negedge clk);
            if (!busy) break;
            len++;
        end
        dn_c = conv_done; dn_k = cal_done;
    endtask

    task automatic pulse_sw();
        sw_conv_set = 1'b1; @(negedge clk); sw_conv_set = 1'b0;
    endtask

    task automatic pulse_stcal();
        stcal_set = 1'b1; @(negedge clk); stcal_set = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int len;
        logic [1:0] kind;
        logic st_c, st_k, swb, stb, dn_c, dn_k;
        int seen;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 bits", {sw_conv_bit, stcal_bit}, 0);
        chk("R1 strobes", {conv_start, conv_done, cal_start, cal_done}, 0);
        chk("R1 kind", cal_kind, 0);
        chk("R1 power", {pwr_full_down, pwr_partial_down}, 0);

        // Vector walk: R2 R3 R4 R5
        foreach (VEC[i]) begin
            cal_mode = VEC[i].mode;
            cal_sel  = VEC[i].sel;
            case (VEC[i].op)
                2'd0: convst_pin = 1'b1;
                2'd1: pulse_sw();
                2'd2: pulse_stcal();
                default: begin
                    cal_pin = 1'b0;
                    repeat (4) @(negedge clk);
                    cal_pin = 1'b1;
                end
            endcase
            measure(len, kind, st_c, st_k, swb, stb, dn_c, dn_k);
            chk($sformatf("R2/R4/R5 vec%0d length", i), len, VEC[i].len);
            chk($sformatf("R2/R4/R5 vec%0d kind", i), kind, VEC[i].kind);
            if (VEC[i].op < 2) begin
                chk($sformatf("R2 vec%0d start/done", i), {st_c, st_k, dn_c, dn_k}, 4'b1010);
                chk($sformatf("R3 vec%0d sw bit during", i), swb, VEC[i].op == 2'd1);
            end else begin
                chk($sformatf("R4 vec%0d start/done", i), {st_c, st_k, dn_c, dn_k}, 4'b0101);
                chk($sformatf("R4 vec%0d stcal bit during", i), stb, VEC[i].op == 2'd2);
            end
            chk($sformatf("R3/R4 vec%0d bits cleared", i), {sw_conv_bit, stcal_bit}, 0);
            convst_pin = 1'b0;
            repeat (4) @(negedge clk);
        end

        // R7 requests during busy are ignored
        convst_pin = 1'b1;
        for (int i = 0; i < 60 && !busy; i++) @(negedge clk);
        len = 1;
        while (busy) begin
            if (len == 4) begin sw_conv_set = 1'b1; stcal_set = 1'b1; end
            else begin sw_conv_set = 1'b0; stcal_set = 1'b0; end
            @(negedge clk);
            if (busy) begin
                len++;
                if (sw_conv_bit || stcal_bit) seen = 99;
            end
        end
        chk("R7 length unchanged", len, CONV);
        chk("R7 bits stay clear", {sw_conv_bit, stcal_bit}, 0);
        seen = 0;
        repeat (8) begin @(negedge clk); if (busy) seen++; end
        chk("R7 no follow-on op", seen, 0);
        convst_pin = 1'b0;
        repeat (4) @(negedge clk);

        // R6 CAL low aborts a conversion without done
        pulse_sw();
        repeat (5) @(negedge clk);
        cal_pin = 1'b0;
        seen = 0;
        repeat (6) begin @(negedge clk); if (conv_done || cal_done) seen++; end
        chk("R6 abort busy low", busy, 0);
        chk("R6 abort no done", seen, 0);
        chk("R6 bits cleared", {sw_conv_bit, stcal_bit}, 0);
        pulse_sw();
        pulse_stcal();
        repeat (4) @(negedge clk);
        chk("R6 starts ignored while low", {busy, sw_conv_bit, stcal_bit}, 0);
        cal_pin = 1'b1;
        measure(len, kind, st_c, st_k, swb, stb, dn_c, dn_k);
        chk("R6 rise then self cal length", len, CSELF);
        repeat (4) @(negedge clk);

        // R6 CAL low aborts a calibration
        cal_mode = 1'b1; cal_sel = 2'b00;
        pulse_stcal();
        repeat (10) @(negedge clk);
        cal_pin = 1'b0;
        seen = 0;
        repeat (6) begin @(negedge clk); if (cal_done) seen++; end
        chk("R6 cal abort busy/stcal", {busy, stcal_bit}, 0);
        chk("R6 cal abort no done", seen, 0);
        cal_pin = 1'b1;
        measure(len, kind, st_c, st_k, swb, stb, dn_c, dn_k);
        repeat (4) @(negedge clk);

        // R10 simultaneous calibration and conversion requests
        cal_mode = 1'b1; cal_sel = 2'b01;
        sw_conv_set = 1'b1; stcal_set = 1'b1;
        @(negedge clk);
        sw_conv_set = 1'b0; stcal_set = 1'b0;
        measure(len, kind, st_c, st_k, swb, stb, dn_c, dn_k);
        chk("R10 calibration wins length", len, COFFS);
        chk("R10 sw bit clear", swb, 0);
        repeat (4) @(negedge clk);

        // R8 R9 sleep gating and power-state selection
        pmgt = 2'b10;
        sleep_n_pin = 1'b0;
        repeat (6) @(negedge clk);
        chk("R9 pmgt10 full", {pwr_full_down, pwr_partial_down}, 2'b10);
        pmgt = 2'b11;
        repeat (2) @(negedge clk);
        chk("R9 pmgt11 partial", {pwr_full_down, pwr_partial_down}, 2'b01);
        pmgt = 2'b10;
        pulse_sw();
        chk("R8 busy entered", busy, 1);
        seen = 0;
        while (busy) begin
            if (pwr_full_down || pwr_partial_down) seen++;
            @(negedge clk);
        end
        chk("R8 no power-down during busy", seen, 0);
        @(negedge clk);
        chk("R8 power-down after end", pwr_full_down, 1);
        sleep_n_pin = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 wake", {pwr_full_down, pwr_partial_down}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule